// File: doc/BRIEF.md
# Host Page-Read Handshake Bridge

This block sits between an external USB microcontroller and a flash page sequencer. The host asks for a page by pulling a control line low. The bridge then requests a page read from the sequencer at the current page address and waits for the sequencer to report the page ready. It pulls a status line low to tell the host it may start strobing, and returns that line high after a programmable number of clock cycles. Each rising edge of the host read strobe moves the next byte of the page onto an 8-bit output bus. When the whole page has been delivered, the bridge advances its page address and waits for the host to return the control line high before it accepts another request.

A separate active-low erase line from the host is qualified by width. A low level that lasts at least a programmed number of cycles launches exactly one block erase in the sequencer. Shorter pulses are treated as glitches. Every host input is brought into the clock domain through a two-flop synchronizer before any decision is made on it.

The read handshake runs in a six-state machine. The states are IDLE, ISSUE, WAIT, SIGNAL, STREAM and DRAIN, with these transitions:
- IDLE to ISSUE when the control line is seen low.
- ISSUE to WAIT always, after one cycle.
- WAIT to SIGNAL when the sequencer reports the page ready.
- SIGNAL to STREAM when the status hold time has expired.
- STREAM to DRAIN when the page is complete.
- DRAIN to IDLE when the control line is seen high.

Top module: `hrb_page_bridge`

## Requirements
- R1: In IDLE, a synchronized low on `host_ctl_n` produces a `seq_read_go` pulse exactly one cycle wide. While that pulse is high, `seq_page_addr` carries the page to be read.
- R2: After a request, `host_stat_n` stays high until `seq_page_ready` has been seen high. It goes low only after that.
- R3: `host_stat_n` stays low for exactly STS_HOLD_CYC clock cycles and then returns high.
- R4: Each synchronized rising edge of `host_rd`, from the time `host_stat_n` falls until PAGE_BYTES bytes have been delivered, loads `seq_byte` into `host_data` and raises `seq_byte_pop` for one cycle. The bytes appear in page order.
- R5: When a page completes, `seq_page_addr` increments by one. A high on `page_clr` forces it to zero, and the clear takes priority over the increment.
- R6: A strobe after the last byte of a page raises no `seq_byte_pop` and leaves `host_data` unchanged. Such a strobe sets `overrun`, which holds until the next page request.
- R7: After a page completes, `host_ctl_n` must be seen high before another request is accepted. A control line held low raises no second `seq_read_go`.
- R8: A low on `host_erase_n` that lasts ERASE_MIN_CYC synchronized cycles produces exactly one `seq_erase_go` pulse. A shorter low produces none.
- R9: While reset is held, the outputs take these values: `host_stat_n`=1, `host_data`=0, `overrun`=0, `seq_page_addr`=0, and `seq_read_go`, `seq_erase_go`, `seq_byte_pop` all 0.
- R10: Strobes that arrive while no page transfer is open (IDLE) raise no `seq_byte_pop` and leave `host_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ctl_n | input | 1 | Host page-read request, active low |
| host_rd | input | 1 | Host read strobe; each rising edge takes one byte |
| host_erase_n | input | 1 | Host erase trigger, active-low pulse |
| page_clr | input | 1 | Synchronous clear of the page address |
| host_stat_n | output | 1 | Status to host; low means the host may start strobing |
| host_data | output | 8 | Byte delivered to the host |
| overrun | output | 1 | Set by a strobe after the page end |
| seq_read_go | output | 1 | One-cycle page-read request to the sequencer |
| seq_page_addr | output | ADDR_W | Page address for the read |
| seq_page_ready | input | 1 | Sequencer has the page data available |
| seq_byte | input | 8 | Head byte offered by the sequencer |
| seq_byte_pop | output | 1 | One-cycle pulse: the head byte was taken |
| seq_erase_go | output | 1 | One-cycle block-erase request to the sequencer |

## Verification
The bench builds the bridge with PAGE_BYTES=16, STS_HOLD_CYC=6, ERASE_MIN_CYC=20 and ADDR_W=8. With a 16-byte page, full transfers, the page-end boundary and the overrun strobe all fit in a few hundred cycles. A six-cycle status hold lets the first strobe land while the status line is still low. A 20-cycle erase threshold lets the bench compare a 10-cycle glitch with a 40-cycle pulse, and it reads two consecutive pages to show the address step and the re-arm rule.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_SIGNAL,
        ST_STREAM,
        ST_DRAIN
    } rd_state_t;
endpackage

// File: rtl/hrb_sync.sv
module hrb_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            dout <= RST_VAL;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/hrb_erase_qual.sv
module hrb_erase_qual #(
    parameter int MIN_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_n_s,
    output logic erase_go
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] FIRE_AT = CW'(MIN_CYC - 1);
    localparam logic [CW-1:0] SAT_AT  = CW'(MIN_CYC);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            erase_go <= 1'b0;
        end else begin
            erase_go <= !erase_n_s && (low_cnt == FIRE_AT);
            if (erase_n_s)
                low_cnt <= '0;
            else if (low_cnt != SAT_AT)
                low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hrb_read_fsm.sv
module hrb_read_fsm
    import hrb_pkg::*;
#(
    parameter int PAGE_BYTES   = 2048,
    parameter int STS_HOLD_CYC = 75,
    parameter int ADDR_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_low,
    input  logic              rd_rise,
    input  logic              page_ready,
    input  logic              page_clr,
    input  logic [7:0]        seq_byte,
    output logic              read_go,
    output logic              stat_n,
    output logic [ADDR_W-1:0] page_addr,
    output logic [7:0]        host_data,
    output logic              byte_pop,
    output logic              overrun
);
    localparam int BCW = $clog2(PAGE_BYTES + 1);
    localparam int HCW = $clog2(STS_HOLD_CYC + 1);
    localparam logic [BCW-1:0] LAST_CNT = BCW'(PAGE_BYTES);
    localparam logic [HCW-1:0] HOLD_END = HCW'(STS_HOLD_CYC - 1);

    rd_state_t state, state_nx;
    logic [BCW-1:0] byte_cnt;
    logic [HCW-1:0] hold_cnt;
    logic           page_full;
    logic           in_xfer;
    logic           may_over;
    logic           deliver;

    assign page_full = (byte_cnt == LAST_CNT);
    assign deliver   = rd_rise && in_xfer && !page_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (ctl_low) state_nx = ST_ISSUE;
            ST_ISSUE:  state_nx = ST_WAIT;
            ST_WAIT:   if (page_ready) state_nx = ST_SIGNAL;
            ST_SIGNAL: if (hold_cnt == HOLD_END) state_nx = ST_STREAM;
            ST_STREAM: if (page_full) state_nx = ST_DRAIN;
            ST_DRAIN:  if (!ctl_low) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        read_go  = 1'b0;
        stat_n   = 1'b1;
        in_xfer  = 1'b0;
        may_over = 1'b0;
        unique case (state)
            ST_ISSUE:  read_go = 1'b1;
            ST_SIGNAL: begin
                stat_n   = 1'b0;
                in_xfer  = 1'b1;
                may_over = 1'b1;
            end
            ST_STREAM: begin
                in_xfer  = 1'b1;
                may_over = 1'b1;
            end
            ST_DRAIN:  may_over = 1'b1;
            default:   ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt  <= '0;
            byte_cnt  <= '0;
            host_data <= '0;
            byte_pop  <= 1'b0;
            overrun   <= 1'b0;
            page_addr <= '0;
        end else begin
            byte_pop <= deliver;
            if (state == ST_SIGNAL)
                hold_cnt <= hold_cnt + 1'b1;
            else
                hold_cnt <= '0;

            if (state == ST_ISSUE)
                byte_cnt <= '0;
            else if (deliver)
                byte_cnt <= byte_cnt + 1'b1;

            if (deliver)
                host_data <= seq_byte;

            if (state == ST_ISSUE)
                overrun <= 1'b0;
            else if (rd_rise && may_over && page_full)
                overrun <= 1'b1;

            if (page_clr)
                page_addr <= '0;
            else if (state == ST_STREAM && page_full)
                page_addr <= page_addr + 1'b1;
        end
    end
endmodule

// File: rtl/hrb_page_bridge.sv
module hrb_page_bridge #(
    parameter int PAGE_BYTES    = 2048,
    parameter int STS_HOLD_CYC  = 75,
    parameter int ERASE_MIN_CYC = 25_000_000,
    parameter int ADDR_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ctl_n,
    input  logic              host_rd,
    input  logic              host_erase_n,
    input  logic              page_clr,
    output logic              host_stat_n,
    output logic [7:0]        host_data,
    output logic              overrun,
    output logic              seq_read_go,
    output logic [ADDR_W-1:0] seq_page_addr,
    input  logic              seq_page_ready,
    input  logic [7:0]        seq_byte,
    output logic              seq_byte_pop,
    output logic              seq_erase_go
);
    logic [2:0] host_s;
    logic       rd_prev;
    logic       rd_rise;

    hrb_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({host_ctl_n, host_erase_n, host_rd}),
        .dout (host_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_prev <= 1'b0;
        else
            rd_prev <= host_s[0];
    end
    assign rd_rise = host_s[0] && !rd_prev;

    hrb_read_fsm #(
        .PAGE_BYTES  (PAGE_BYTES),
        .STS_HOLD_CYC(STS_HOLD_CYC),
        .ADDR_W      (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_low   (!host_s[2]),
        .rd_rise   (rd_rise),
        .page_ready(seq_page_ready),
        .page_clr  (page_clr),
        .seq_byte  (seq_byte),
        .read_go   (seq_read_go),
        .stat_n    (host_stat_n),
        .page_addr (seq_page_addr),
        .host_data (host_data),
        .byte_pop  (seq_byte_pop),
        .overrun   (overrun)
    );

    hrb_erase_qual #(.MIN_CYC(ERASE_MIN_CYC)) u_erase (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_n_s(host_s[1]),
        .erase_go (seq_erase_go)
    );
endmodule

// File: rtl/hrb_page_bridge_chk.sv
module hrb_page_bridge_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_stat_n,
    input logic              overrun,
    input logic              seq_read_go,
    input logic [ADDR_W-1:0] seq_page_addr,
    input logic              seq_page_ready,
    input logic              seq_byte_pop,
    input logic              seq_erase_go
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    a_r1_go_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_read_go |=> !seq_read_go);

    a_r2_stat_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_stat_n) |-> $past(seq_page_ready));

    a_r3_no_request_while_ready_shown: assert property (@(posedge clk) disable iff (!rst_n)
        !host_stat_n |-> !seq_read_go);

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_page_addr) |->
            (seq_page_addr == '0 || seq_page_addr == $past(seq_page_addr) + ONE));

    a_r6_overrun_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> !seq_byte_pop);

    a_r8_erase_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_erase_go |=> !seq_erase_go);
endmodule

bind hrb_page_bridge hrb_page_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_stat_n   (host_stat_n),
    .overrun       (overrun),
    .seq_read_go   (seq_read_go),
    .seq_page_addr (seq_page_addr),
    .seq_page_ready(seq_page_ready),
    .seq_byte_pop  (seq_byte_pop),
    .seq_erase_go  (seq_erase_go)
);

// File: tb/hrb_page_bridge_tb.sv
module hrb_page_bridge_tb;
    localparam int PB = 16;
    localparam int HOLD = 6;
    localparam int EMIN = 20;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_ctl_n = 1'b1, host_rd = 1'b0, host_erase_n = 1'b1, page_clr = 1'b0;
    logic host_stat_n, overrun, seq_read_go, seq_byte_pop, seq_erase_go;
    logic [7:0] host_data, seq_byte;
    logic [AW-1:0] seq_page_addr;
    logic seq_page_ready = 1'b0;

    int checks = 0, errors = 0;
    int go_cnt = 0, erase_cnt = 0, pop_cnt = 0;
    int last_go_addr = -1, low_run = 0, last_low = 0;
    int model_page = 0, model_ptr = 0, lat = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    hrb_page_bridge #(.PAGE_BYTES(PB), .STS_HOLD_CYC(HOLD),
                      .ERASE_MIN_CYC(EMIN), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_ctl_n(host_ctl_n), .host_rd(host_rd),
        .host_erase_n(host_erase_n), .page_clr(page_clr),
        .host_stat_n(host_stat_n), .host_data(host_data), .overrun(overrun),
        .seq_read_go(seq_read_go), .seq_page_addr(seq_page_addr),
        .seq_page_ready(seq_page_ready), .seq_byte(seq_byte),
        .seq_byte_pop(seq_byte_pop), .seq_erase_go(seq_erase_go));

    function automatic logic [7:0] pat(input int pg, input int idx);
        return 8'((pg * 37 + idx * 5 + 3) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // sequencer model
    assign seq_byte = pat(model_page, model_ptr);
    always @(posedge clk) begin
        if (seq_read_go) begin
            model_page <= int'(seq_page_addr);
            model_ptr <= 0;
            seq_page_ready <= 1'b0;
            lat <= 10;
        end else if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) seq_page_ready <= 1'b1;
        end
        if (seq_byte_pop) model_ptr <= model_ptr + 1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (seq_read_go) begin go_cnt++; last_go_addr = int'(seq_page_addr); end
            if (seq_erase_go) erase_cnt++;
            if (!host_stat_n) begin
                if (low_run == 0)
                    check(seq_page_ready, "R2", "status low before page ready", 0, 1);
                low_run++;
            end else if (low_run != 0) begin
                last_low = low_run;
                low_run = 0;
            end
            if (seq_byte_pop) begin
                pop_cnt++;
                if (exp_q.size() == 0)
                    check(0, "R4", "unexpected byte pop", int'(host_data), -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(host_data == e, "R4", "delivered byte", int'(host_data), int'(e));
                end
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        host_rd = 1'b1; cycles(3);
        host_rd = 1'b0; cycles(3);
    endtask

    task automatic read_page(input int pg);
        for (int i = 0; i < PB; i++) begin
            exp_q.push_back(pat(pg, i));
            strobe();
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            check(0, "WDOG", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pops, d;
        cycles(2);
        // R9 reset values
        check(host_stat_n == 1'b1, "R9", "stat_n in reset", int'(host_stat_n), 1);
        check(host_data == 8'd0 && overrun == 1'b0, "R9", "data/overrun in reset",
              int'(host_data) + int'(overrun), 0);
        check(seq_page_addr == '0 && !seq_read_go && !seq_erase_go && !seq_byte_pop,
              "R9", "sequencer outputs in reset", int'(seq_page_addr), 0);
        cycles(2);
        rst_n = 1'b1;
        cycles(3);

        // R10 strobe while idle
        strobe();
        check(pop_cnt == 0, "R10", "pops from idle strobe", pop_cnt, 0);
        check(host_data == 8'd0, "R10", "data after idle strobe", int'(host_data), 0);

        // R1, R2, R3, R4 page 0
        host_ctl_n = 1'b0;
        while (go_cnt == 0) cycles(1);
        check(last_go_addr == 0, "R1", "request page address", last_go_addr, 0);
        cycles(1);
        check(!seq_read_go, "R1", "request pulse width", int'(seq_read_go), 0);
        check(host_stat_n == 1'b1, "R2", "status before ready", int'(host_stat_n), 1);
        while (host_stat_n) cycles(1);
        read_page(0);
        cycles(2);
        check(pop_cnt == PB, "R4", "bytes delivered page 0", pop_cnt, PB);
        check(exp_q.size() == 0, "R4", "bytes left undelivered", exp_q.size(), 0);
        check(last_low == HOLD, "R3", "status low width", last_low, HOLD);
        check(int'(seq_page_addr) == 1, "R5", "address after page 0", int'(seq_page_addr), 1);

        // R6 overrun strobe
        pops = pop_cnt; d = int'(host_data);
        strobe();
        check(pop_cnt == pops, "R6", "pops on overrun strobe", pop_cnt, pops);
        check(int'(host_data) == d, "R6", "data on overrun strobe", int'(host_data), d);
        check(overrun == 1'b1, "R6", "overrun flag", int'(overrun), 1);

        // R7 control held low
        cycles(30);
        check(go_cnt == 1, "R7", "requests while ctl held low", go_cnt, 1);
        host_ctl_n = 1'b1; cycles(6);
        check(overrun == 1'b1, "R6", "overrun held until request", int'(overrun), 1);
        host_ctl_n = 1'b0;
        while (go_cnt == 1) cycles(1);
        check(last_go_addr == 1, "R1", "second page address", last_go_addr, 1);
        cycles(2);
        check(overrun == 1'b0, "R6", "overrun cleared by request", int'(overrun), 0);
        while (host_stat_n) cycles(1);
        read_page(1);
        cycles(2);
        check(pop_cnt == 2 * PB, "R4", "bytes delivered page 1", pop_cnt, 2 * PB);
        check(int'(seq_page_addr) == 2, "R5", "address after page 1", int'(seq_page_addr), 2);
        host_ctl_n = 1'b1; cycles(6);

        // R5 clear
        page_clr = 1'b1; cycles(1); page_clr = 1'b0; cycles(1);
        check(seq_page_addr == '0, "R5", "address after clear", int'(seq_page_addr), 0);

        // R8 erase qualification
        host_erase_n = 1'b0; cycles(10); host_erase_n = 1'b1; cycles(30);
        check(erase_cnt == 0, "R8", "erase from short pulse", erase_cnt, 0);
        host_erase_n = 1'b0; cycles(40);
        check(erase_cnt == 1, "R8", "erase during long pulse", erase_cnt, 1);
        host_erase_n = 1'b1; cycles(10);
        check(erase_cnt == 1, "R8", "erase count after release", erase_cnt, 1);
        host_erase_n = 1'b0; cycles(30); host_erase_n = 1'b1; cycles(10);
        check(erase_cnt == 2, "R8", "erase from second pulse", erase_cnt, 2);
        check(go_cnt == 2, "R7", "no stray read requests", go_cnt, 2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule